// File: doc/BRIEF.md
# Bank Precharge and Activate Timing Guard

This block follows the commands a DDR2-style memory controller sends to a single bank and tells the controller when the next precharge or activate may legally go out. It sees the activate, read and precharge strobes for its bank. It takes the programmed additive latency, CAS latency, burst length (4 or 8), and the read-to-precharge, activate-to-precharge and precharge-to-activate times, all counted in clock cycles.

The earliest legal precharge after a read is the later of two points. The first is the read spacing: additive latency, plus half the burst length, plus the larger of the read-to-precharge time and 2, minus 2. The second is the activate-to-precharge minimum. The guard also reports the read latency (additive plus CAS latency). If a precharge or activate is issued while its permission flag is low, a sticky violation flag is raised and the command is still tracked. The latency settings are taken only while the bank is closed, and all timing is kept in saturating 6-bit down-counters.

Top module: `bank_pre_guard`

## Requirements
- R1: `read_lat` equals AL + CL of the settings in force. These are the live inputs while the bank is closed, and the values captured at the last closed cycle while it is open.
- R2: With `cfg_bl8`=0, after a read in cycle t, `pre_ok` can be high no earlier than cycle t + AL + max(tRTP, 2). From that cycle on it is high, provided the bank is open and R4 is met.
- R3: With `cfg_bl8`=1, the read spacing is AL + 2 + max(tRTP, 2) cycles after the read.
- R4: `pre_ok` stays low until cycle t + tRAS after an activate in cycle t, whatever the read spacing allows.
- R5: `pre_ok` is low whenever the bank is closed. After a precharge in cycle t, `act_ok` is low until cycle t + tRP and high from then until the next activate.
- R6: A read issued while an earlier read's spacing is still running restarts the spacing from the new read.
- R7: A precharge while `pre_ok` is low, or an activate while `act_ok` is low, sets `violation` in the next cycle. `violation` stays set until reset, and the command is still tracked.
- R8: Changes to AL, CL, burst length or tRTP while the bank is open have no effect on `read_lat` or on the read spacing.
- R9: Right after reset the bank is closed, `pre_ok`=0, `act_ok`=1 and `violation`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_act | input | 1 | Activate issued to this bank this cycle |
| cmd_rd | input | 1 | Read issued to this bank this cycle |
| cmd_pre | input | 1 | Precharge issued to this bank this cycle |
| cfg_al | input | 3 | Additive latency in cycles |
| cfg_cl | input | 3 | CAS latency in cycles |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfg_trtp | input | 4 | Read-to-precharge time in cycles |
| cfg_tras | input | 6 | Activate-to-precharge minimum in cycles |
| cfg_trp | input | 4 | Precharge-to-activate time in cycles |
| pre_ok | output | 1 | A precharge is legal this cycle |
| act_ok | output | 1 | An activate is legal this cycle |
| read_lat | output | 4 | AL + CL |
| violation | output | 1 | Sticky flag for an early precharge or activate |

## Verification
The properties assume that at most one of the three command strobes is high in any cycle. The controller's arbitration guarantees this, and the stimulus only ever pulses one strobe for a single cycle. The properties that tie a read or a precharge to the next cycle's flags rely on the read spacing being at least two cycles, which the formula always gives. The stimulus moves the settings only between commands. It changes them while the bank is open just once, to show that they are ignored. Early commands are sent only in the final scenarios, and each of those is followed by a reset.

// File: rtl/bpg_pkg.sv
// Shared widths and the latched latency settings for the bank timing guard.
// Assumes all timing values are whole clock cycles.
package bpg_pkg;
    localparam int AL_W   = 3;
    localparam int CL_W   = 3;
    localparam int TRTP_W = 4;
    localparam int TRP_W  = 4;
    localparam int CNT_W  = 6;

    typedef struct packed {
        logic [AL_W-1:0]   al;
        logic [CL_W-1:0]   cl;
        logic              bl8;
        logic [TRTP_W-1:0] trtp;
    } lat_cfg_t;
endpackage

// File: rtl/bpg_downcnt.sv
// Saturating down-counter. A load of N makes the counter reach zero N cycles
// after the load cycle (N = 0 reads as zero straight away). It assumes
// load_val already fits the counter width.
module bpg_downcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load N-1 on a command, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bpg_spacing.sv
// Works out the read-to-precharge spacing AL + BL/2 + max(tRTP,2) - 2, which
// is AL + (BL8 ? 2 : 0) + max(tRTP,2). The result saturates at the counter
// width. Purely combinational.
module bpg_spacing
    import bpg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  lat_cfg_t        cfg,
    output logic [CW-1:0]   spacing
);
    localparam int SW = CW + 2;
    localparam logic [SW-1:0] LIMIT = SW'((1 << CW) - 1);

    logic [SW-1:0] rtp_eff;
    logic [SW-1:0] sum;

    // Clamp tRTP to at least 2, add the burst term, then saturate.
    always_comb begin
        rtp_eff = (cfg.trtp > TRTP_W'(2)) ? SW'(cfg.trtp) : SW'(2);
        sum     = SW'(cfg.al) + (cfg.bl8 ? SW'(2) : SW'(0)) + rtp_eff;
        spacing = (sum > LIMIT) ? LIMIT[CW-1:0] : sum[CW-1:0];
    end
endmodule

// File: rtl/bpg_cfg_hold.sv
// Captures the latency settings in every cycle the bank is closed and holds
// them while it is open. The effective output is the live input while closed.
module bpg_cfg_hold
    import bpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bank_open,
    input  lat_cfg_t cfg_in,
    output lat_cfg_t cfg_eff
);
    lat_cfg_t cfg_q;

    // Keep sampling while idle so the activate edge captures the final value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!bank_open) begin
            cfg_q <= cfg_in;
        end
    end

    assign cfg_eff = bank_open ? cfg_q : cfg_in;
endmodule

// File: rtl/bank_pre_guard.sv
// Per-bank timing guard. It tracks activate, read and precharge for one bank
// and flags when a precharge or activate is legal. It assumes at most one
// command strobe per cycle. Early commands set a sticky violation flag but are
// still tracked.
module bank_pre_guard
    import bpg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_act,
    input  logic              cmd_rd,
    input  logic              cmd_pre,
    input  logic [AL_W-1:0]   cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic              cfg_bl8,
    input  logic [TRTP_W-1:0] cfg_trtp,
    input  logic [CW-1:0]     cfg_tras,
    input  logic [TRP_W-1:0]  cfg_trp,
    output logic              pre_ok,
    output logic              act_ok,
    output logic [AL_W:0]     read_lat,
    output logic              violation
);
    lat_cfg_t      cfg_live;
    lat_cfg_t      cfg_eff;
    logic [CW-1:0] rd_space;
    logic          open_q;
    logic          rd_done;
    logic          ras_done;
    logic          rp_done;
    logic          viol_q;

    assign cfg_live = '{al: cfg_al, cl: cfg_cl, bl8: cfg_bl8, trtp: cfg_trtp};

    bpg_cfg_hold u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_open (open_q),
        .cfg_in    (cfg_live),
        .cfg_eff   (cfg_eff)
    );

    bpg_spacing #(.CW(CW)) u_space (
        .cfg     (cfg_eff),
        .spacing (rd_space)
    );

    bpg_downcnt #(.W(CW)) u_rd_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_rd),
        .load_val (rd_space),
        .expired  (rd_done)
    );

    bpg_downcnt #(.W(CW)) u_ras_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_act),
        .load_val (cfg_tras),
        .expired  (ras_done)
    );

    bpg_downcnt #(.W(CW)) u_rp_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_pre),
        .load_val (CW'(cfg_trp)),
        .expired  (rp_done)
    );

    // Bank open state: an activate opens the bank, a precharge closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (cmd_pre) begin
            open_q <= 1'b0;
        end else if (cmd_act) begin
            open_q <= 1'b1;
        end
    end

    assign pre_ok = open_q && rd_done && ras_done;
    assign act_ok = !open_q && rp_done;

    // Sticky flag for a precharge or activate sent before it was legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if ((cmd_pre && !pre_ok) || (cmd_act && !act_ok)) begin
            viol_q <= 1'b1;
        end
    end

    assign violation = viol_q;
    assign read_lat  = (AL_W+1)'(cfg_eff.al) + (AL_W+1)'(cfg_eff.cl);
endmodule

// File: rtl/bpg_checker.sv
// Properties for bank_pre_guard. Assumes one command strobe per cycle.
module bpg_checker #(
    parameter int RLW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_act,
    input logic           cmd_rd,
    input logic           cmd_pre,
    input logic           pre_ok,
    input logic           act_ok,
    input logic           violation,
    input logic [RLW-1:0] read_lat,
    input logic           bank_open
);
    // R5
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |=> !pre_ok);
    // R5
    pre_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ok |-> bank_open);
    // R5
    act_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |=> !act_ok);
    // R2
    read_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> !pre_ok);
    // R7
    early_cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_pre && !pre_ok) || (cmd_act && !act_ok)) |=> violation);
    // R7
    violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    // R8
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open && $past(bank_open)) |-> $stable(read_lat));
endmodule

bind bank_pre_guard bpg_checker #(.RLW(bpg_pkg::AL_W + 1)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_act   (cmd_act),
    .cmd_rd    (cmd_rd),
    .cmd_pre   (cmd_pre),
    .pre_ok    (pre_ok),
    .act_ok    (act_ok),
    .violation (violation),
    .read_lat  (read_lat),
    .bank_open (open_q)
);

// File: tb/test_bank_pre_guard.sv
module test_bank_pre_guard;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cmd_act = 0, cmd_rd = 0, cmd_pre = 0;
    logic [2:0] cfg_al = 0, cfg_cl = 3;
    logic       cfg_bl8 = 0;
    logic [3:0] cfg_trtp = 2;
    logic [5:0] cfg_tras = 3;
    logic [3:0] cfg_trp = 2;
    logic       pre_ok, act_ok, violation;
    logic [3:0] read_lat;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    string tag = "R9";

    // reference model state
    bit m_open = 0, m_viol = 0, m_bl8 = 0;
    int m_al = 0, m_cl = 0, m_trtp = 0;
    int m_rd_t = -1000, m_rd_s = 0, m_act_t = -1000, m_tras = 0;
    int m_pre_t = -1000, m_trp = 0;

    always #10 clk = ~clk;

    bank_pre_guard i_bank_pre_guard (
        .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
        .cmd_pre(cmd_pre), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .cfg_trtp(cfg_trtp), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .pre_ok(pre_ok), .act_ok(act_ok), .read_lat(read_lat),
        .violation(violation)
    );

    function automatic int space_of(int al, bit bl8, int trtp);
        int s = al + (bl8 ? 4 : 2) + (trtp > 2 ? trtp : 2) - 2;
        return (s > 63) ? 63 : s;
    endfunction

    function automatic bit exp_pre(int c);
        return m_open && (c >= m_rd_t + m_rd_s) && (c >= m_act_t + m_tras);
    endfunction

    function automatic bit exp_act(int c);
        return !m_open && (c >= m_pre_t + m_trp);
    endfunction

    function automatic int exp_lat();
        return m_open ? (m_al + m_cl) : (int'(cfg_al) + int'(cfg_cl));
    endfunction

    // Behavioural model, stepped at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_viol = 0; m_rd_t = -1000; m_rd_s = 0;
            m_act_t = -1000; m_tras = 0; m_pre_t = -1000; m_trp = 0;
        end else begin
            bit ep, ea;
            ep = exp_pre(cyc);
            ea = exp_act(cyc);
            if (!m_open) begin
                m_al = cfg_al; m_cl = cfg_cl; m_bl8 = cfg_bl8; m_trtp = cfg_trtp;
            end
            if (cmd_act) begin
                if (!ea) m_viol = 1;
                m_open = 1; m_act_t = cyc; m_tras = cfg_tras;
            end
            if (cmd_rd) begin
                m_rd_t = cyc; m_rd_s = space_of(m_al, m_bl8, m_trtp);
            end
            if (cmd_pre) begin
                if (!ep) m_viol = 1;
                m_open = 0; m_pre_t = cyc; m_trp = cfg_trp;
            end
        end
        cyc++;
    end

    task automatic check(string what, int act_v, int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act_v, exp_v, cyc);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("pre_ok", pre_ok, exp_pre(cyc));
            check("act_ok", act_ok, exp_act(cyc));
            check("read_lat", read_lat, exp_lat());
            check("violation", violation, m_viol);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic pulse(int kind);
        @(negedge clk); #2;
        cmd_act = (kind == 0); cmd_rd = (kind == 1); cmd_pre = (kind == 2);
        @(negedge clk); #2;
        cmd_act = 0; cmd_rd = 0; cmd_pre = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); #2;
        rst_n = 0;
        idle(2);
        tag = "R9";
        check("reset pre_ok", pre_ok, 0);
        check("reset act_ok", act_ok, 1);
        check("reset violation", violation, 0);
        rst_n = 1;
    endtask

    task automatic set_cfg(int al, int cl, bit bl8, int trtp, int tras, int trp);
        cfg_al = al[2:0]; cfg_cl = cl[2:0]; cfg_bl8 = bl8;
        cfg_trtp = trtp[3:0]; cfg_tras = tras[5:0]; cfg_trp = trp[3:0];
    endtask

    // One open/read/close round with generous waits; the model checks edges.
    task automatic round(int al, int cl, bit bl8, int trtp, int tras, int trp);
        set_cfg(al, cl, bl8, trtp, tras, trp);
        idle(1);
        pulse(0);
        pulse(1);
        idle(30);
        pulse(2);
        idle(18);
    endtask

    initial begin
        do_reset();
        tag = "R1"; round(1, 3, 0, 1, 3, 2);
        tag = "R1"; round(2, 3, 0, 2, 3, 2);
        tag = "R2"; round(2, 4, 0, 5, 2, 3);
        tag = "R2"; round(0, 3, 0, 0, 0, 0);
        tag = "R3"; round(1, 3, 1, 3, 2, 2);
        tag = "R3"; round(3, 5, 1, 1, 1, 2);
        tag = "R4"; round(1, 3, 0, 2, 25, 2);

        // R6: a second read restarts the spacing
        tag = "R6";
        set_cfg(2, 3, 1, 4, 1, 2);
        idle(1); pulse(0); pulse(1); idle(3); pulse(1); idle(20); pulse(2); idle(18);

        // R8: settings moved while open are ignored
        tag = "R8";
        set_cfg(1, 3, 0, 2, 2, 2);
        idle(1); pulse(0);
        set_cfg(7, 7, 1, 15, 2, 2);
        idle(2);
        check("held read_lat R8", read_lat, 4);
        pulse(1); idle(30); pulse(2); idle(18);

        // R5: precharge-to-activate window, then an activate right on time
        tag = "R5";
        set_cfg(1, 3, 0, 2, 2, 6);
        idle(1); pulse(0); pulse(1); idle(10); pulse(2);
        idle(4);
        pulse(0); idle(10); pulse(2); idle(18);

        // R7: early precharge sets a sticky violation
        tag = "R7";
        set_cfg(2, 3, 1, 4, 2, 3);
        idle(1); pulse(0); pulse(1); pulse(2); idle(10);
        check("sticky violation R7", violation, 1);
        do_reset();

        // R7: early activate after a precharge
        tag = "R7";
        set_cfg(0, 3, 0, 2, 1, 8);
        idle(1); pulse(0); idle(5); pulse(2); pulse(0); idle(10);
        check("activate violation R7", violation, 1);
        do_reset();
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule